// File: doc/BRIEF.md
# Eight-bit Timer/Counter with Compare Match

This block is an 8-bit timer/counter with one output-compare channel and a small register interface. A clock-select field picks where its count ticks come from: the system clock directly, one of four taps of a free-running prescaler, or either edge of an external pin. On each tick the counter moves by one step, set by the active mode. Normal mode counts up and wraps. Up/down mode reverses direction at both ends of the range.

A comparator checks the count against a compare register at all times. When the two are equal, a tick sets the compare flag and can drive a waveform pin. That pin can toggle, clear or set. The compare flag and an overflow flag each raise an interrupt request when their own enable and a global enable input are both high. Software reads and writes the counter, the compare value, the control byte and the flags through a four-register map with a single write strobe and a combinational read port.

Register map (2-bit address): 0 = control, 1 = counter, 2 = compare, 3 = flags.
- Control bits:
  - [2:0] tick source
  - [3] up/down mode
  - [5:4] wave mode
  - [6] compare interrupt enable
  - [7] overflow interrupt enable
- Flags bits:
  - bit 0 is the compare flag.
  - bit 1 is the overflow flag.
  - The other bits read 0.

Top module: `tmr8_cmp`

## Requirements
- R1: After reset, all four registers read 0, the wave output is 0, at_bottom is 1 and at_top is 0.
- R2: With tick-source code 0 the counter holds its value.
- R3: The counter can be written and read back at address 1 whether the timer is stopped or running.
- R4: A counter write takes priority over a count step in the same cycle, so the written value is what reads back.
- R5: The tick-source codes are:
  - 1 = every clock
  - 2 = clock/8
  - 3 = clock/64
  - 4 = clock/256
  - 5 = clock/1024
  - 6 = falling edge of ext_in
  - 7 = rising edge of ext_in

  ext_in passes through a two-flop synchronizer before edge detection.
- R6: The compare flag (flags bit 0) is set by a tick that occurs while the count equals the compare register. Equality without a tick does not set it.
- R7: irq_cmp is high exactly when the compare flag, control bit 6 and gie are all high. irq_ovf is high exactly when the overflow flag, control bit 7 and gie are all high.
- R8: The compare flag clears on a one-cycle cmp_ack pulse or on a write of 1 to flags bit 0. Writing 0 to that bit leaves it unchanged. The overflow flag clears on a write of 1 to flags bit 1.
- R9: In normal mode (control bit 3 = 0) each tick adds one. A tick at 0xFF gives 0x00 and sets the overflow flag.
- R10: In up/down mode (control bit 3 = 1) a tick at 0xFF gives 0xFE and turns the count downward. A tick at 0x00 gives 0x01, turns it upward and sets the overflow flag. Passing 0xFF does not set that flag.
- R11: On a compare-match tick, the wave mode (control bits 5:4) acts as follows:
  - 0: disconnects the pin, which is driven 0.
  - 1: toggles the pin.
  - 2: clears the pin.
  - 3: sets the pin.
- R12: The first tick after a counter write does not change the wave output, even on a match.
- R13: at_top is 1 exactly when the count is 0xFF, and at_bottom is 1 exactly when it is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_in | input | 1 | External tick pin, asynchronous |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| gie | input | 1 | Global interrupt enable |
| cmp_ack | input | 1 | Compare interrupt acknowledge pulse |
| irq_cmp | output | 1 | Compare interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |
| wave_out | output | 1 | Compare waveform output |
| at_top | output | 1 | Count is at its maximum |
| at_bottom | output | 1 | Count is zero |

## Verification
A corrupted count or a wrong direction bit shows on the counter read port at the first tick after the fault. It also shows on at_top and at_bottom in the same cycle as the bad count. A bad write-block bit or a bad match decision appears on wave_out or in flags bit 0 at the match tick itself, and the bench samples exactly that cycle. Prescaler or synchronizer faults change how many ticks fall in a fixed window, and this becomes visible as a wrong count at the end of the window.

// File: rtl/tmr8_pkg.sv
// Package: shared types and register addresses for the 8-bit timer.
// Assumes an 8-bit register bus with a 2-bit address.
package tmr8_pkg;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_CNT  = 2'd1;
    localparam logic [1:0] A_CMP  = 2'd2;
    localparam logic [1:0] A_FLG  = 2'd3;

    typedef enum logic [1:0] {
        WAV_OFF = 2'd0,
        WAV_TOG = 2'd1,
        WAV_CLR = 2'd2,
        WAV_SET = 2'd3
    } wav_mode_e;

    typedef struct packed {
        logic       ovf_ie;
        logic       cmp_ie;
        wav_mode_e  wav;
        logic       updown;
        logic [2:0] src;
    } ctrl_t;

endpackage

// File: rtl/tmr8_tick.sv
// Tick generator: picks the count-tick source from a free-running prescaler
// or from a synchronized external pin. Assumes PRE_W >= 10 so that the
// divide-by-1024 tap exists. The tick is a one-cycle pulse.
module tmr8_tick #(
    parameter int PRE_W = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] src,
    input  logic       ext_in,
    output logic       tick
);
    localparam int TAP8    = 3;
    localparam int TAP64   = 6;
    localparam int TAP256  = 8;
    localparam int TAP1024 = 10;

    logic [PRE_W-1:0] pre_q;
    logic [2:0]       sync_q;

    // Free-running prescaler.
    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_q + 1'b1;
    end

    // Two-flop synchronizer plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 3'b000;
        else        sync_q <= {sync_q[1:0], ext_in};
    end

    // Tick source selection.
    always_comb begin
        case (src)
            3'd1:    tick = 1'b1;
            3'd2:    tick = &pre_q[TAP8-1:0];
            3'd3:    tick = &pre_q[TAP64-1:0];
            3'd4:    tick = &pre_q[TAP256-1:0];
            3'd5:    tick = &pre_q[TAP1024-1:0];
            3'd6:    tick = sync_q[2] & ~sync_q[1];
            3'd7:    tick = sync_q[1] & ~sync_q[2];
            default: tick = 1'b0;
        endcase
    end

endmodule

// File: rtl/tmr8_count.sv
// Counter core: an up/down counter with write priority and top/bottom
// decode. It reports the overflow event. Assumes that tick is a one-cycle
// pulse.
module tmr8_count #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             updown,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] cnt,
    output logic             at_top,
    output logic             at_bot,
    output logic             ovf_evt
);
    localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

    logic [CNT_W-1:0] nxt;
    logic             dir_up, dir_n;

    assign at_top = (cnt == MAXV);
    assign at_bot = (cnt == '0);

    // Next count and next direction for the selected mode.
    always_comb begin
        nxt   = cnt;
        dir_n = dir_up;
        if (!updown) begin
            dir_n = 1'b1;
            if (tick) nxt = cnt + 1'b1;
        end else if (tick) begin
            if (dir_up) begin
                if (at_top) begin
                    nxt   = MAXV - 1'b1;
                    dir_n = 1'b0;
                end else begin
                    nxt = cnt + 1'b1;
                end
            end else begin
                if (at_bot) begin
                    nxt   = {{(CNT_W-1){1'b0}}, 1'b1};
                    dir_n = 1'b1;
                end else begin
                    nxt = cnt - 1'b1;
                end
            end
        end
    end

    assign ovf_evt = tick && !wr_en && (updown ? at_bot : at_top);

    // Count register; a bus write beats any step.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (wr_en) cnt <= wr_data;
        else            cnt <= nxt;
    end

    // Direction register; held across a write, forced up in normal mode.
    always_ff @(posedge clk) begin
        if (!rst_n)     dir_up <= 1'b1;
        else if (wr_en) dir_up <= updown ? dir_up : 1'b1;
        else            dir_up <= dir_n;
    end

    p_cnt_write_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> cnt == $past(wr_data));
    p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_en) |=> cnt == $past(cnt));
    p_cnt_normal_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_en && !updown) |=> cnt == CNT_W'($past(cnt) + 1'b1));
    p_cnt_ud_turn_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_en && updown && cnt == MAXV) |=> cnt == MAXV - 1'b1);

endmodule

// File: rtl/tmr8_cmp_unit.sv
// Compare unit: detects equality, sets the compare flag on a tick at
// equality, and drives the wave register. Assumes that tick is a one-cycle
// pulse and that flag_clr is already decoded.
module tmr8_cmp_unit
    import tmr8_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    input  logic             cnt_wr,
    input  wav_mode_e        wav,
    input  logic             flag_clr,
    output logic             flag,
    output logic             wave_q
);
    logic hit, blk;

    assign hit = tick && (cnt == cmp);

    // Block the wave action until the first tick after a counter write.
    always_ff @(posedge clk) begin
        if (!rst_n)      blk <= 1'b0;
        else if (cnt_wr) blk <= 1'b1;
        else if (tick)   blk <= 1'b0;
    end

    // Compare flag; a set wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag <= 1'b0;
        else if (hit)      flag <= 1'b1;
        else if (flag_clr) flag <= 1'b0;
    end

    // Wave register update on an unblocked match.
    always_ff @(posedge clk) begin
        if (!rst_n) wave_q <= 1'b0;
        else if (hit && !blk) begin
            case (wav)
                WAV_TOG: wave_q <= ~wave_q;
                WAV_CLR: wave_q <= 1'b0;
                WAV_SET: wave_q <= 1'b1;
                default: wave_q <= wave_q;
            endcase
        end
    end

    p_cmpflag_from_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(tick) && $past(cnt) == $past(cmp));
    p_wave_blocked_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (blk && !cnt_wr) |=> $stable(wave_q));

endmodule

// File: rtl/tmr8_cmp.sv
// Top level: register file, flag logic and interrupt gating around the tick
// generator, the counter core and the compare unit. Assumes a single-cycle
// bus write strobe and an asynchronous read.
module tmr8_cmp
    import tmr8_pkg::*;
#(
    parameter int PRE_W = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ext_in,
    input  logic       bus_we,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       gie,
    input  logic       cmp_ack,
    output logic       irq_cmp,
    output logic       irq_ovf,
    output logic       wave_out,
    output logic       at_top,
    output logic       at_bottom
);
    localparam int CNT_W = 8;

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] cmp_q, cnt;
    logic             ovf_q, tick, ovf_evt, cmp_flag, wave_q;
    logic             wr_ctrl, wr_cnt, wr_cmp, wr_flg;

    assign wr_ctrl = bus_we && bus_addr == A_CTRL;
    assign wr_cnt  = bus_we && bus_addr == A_CNT;
    assign wr_cmp  = bus_we && bus_addr == A_CMP;
    assign wr_flg  = bus_we && bus_addr == A_FLG;

    // Control and compare registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            cmp_q  <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata);
            if (wr_cmp)  cmp_q  <= bus_wdata;
        end
    end

    // Overflow flag; a set wins over a write-one clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                     ovf_q <= 1'b0;
        else if (ovf_evt)               ovf_q <= 1'b1;
        else if (wr_flg && bus_wdata[1]) ovf_q <= 1'b0;
    end

    tmr8_tick #(.PRE_W(PRE_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .src    (ctrl_q.src),
        .ext_in (ext_in),
        .tick   (tick)
    );

    tmr8_count #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .updown  (ctrl_q.updown),
        .wr_en   (wr_cnt),
        .wr_data (bus_wdata),
        .cnt     (cnt),
        .at_top  (at_top),
        .at_bot  (at_bottom),
        .ovf_evt (ovf_evt)
    );

    tmr8_cmp_unit #(.CNT_W(CNT_W)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .cnt      (cnt),
        .cmp      (cmp_q),
        .cnt_wr   (wr_cnt),
        .wav      (ctrl_q.wav),
        .flag_clr (cmp_ack || (wr_flg && bus_wdata[0])),
        .flag     (cmp_flag),
        .wave_q   (wave_q)
    );

    assign wave_out = (ctrl_q.wav == WAV_OFF) ? 1'b0 : wave_q;
    assign irq_cmp  = cmp_flag && ctrl_q.cmp_ie && gie;
    assign irq_ovf  = ovf_q && ctrl_q.ovf_ie && gie;

    // Combinational register read.
    always_comb begin
        case (bus_addr)
            A_CTRL:  bus_rdata = ctrl_q;
            A_CNT:   bus_rdata = cnt;
            A_CMP:   bus_rdata = cmp_q;
            default: bus_rdata = {6'b0, ovf_q, cmp_flag};
        endcase
    end

    p_ovf_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_cnt && !ctrl_q.updown && at_top) |=> ovf_q);
    p_ovf_not_at_top_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.updown && !ovf_q && !at_bottom) |=> !$rose(ovf_q) || $past(at_bottom));

endmodule

// File: tb/sim_tmr8_cmp.sv
module sim_tmr8_cmp;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_in = 1'b0;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       gie = 1'b0;
    logic       cmp_ack = 1'b0;
    logic       irq_cmp, irq_ovf, wave_out, at_top, at_bottom;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    tmr8_cmp u0 (
        .clk(clk), .rst_n(rst_n), .ext_in(ext_in), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .gie(gie), .cmp_ack(cmp_ack), .irq_cmp(irq_cmp), .irq_ovf(irq_ovf),
        .wave_out(wave_out), .at_top(at_top), .at_bottom(at_bottom)
    );

    // Table format: {op[1:0], addr[1:0], data[7:0], exp[7:0], req[3:0]}
    // op 0 = write, 1 = read and compare, 2 = idle for data cycles.
    localparam int NV = 20;
    localparam logic [23:0] VEC [NV] = '{
        {2'd1, 2'd1, 8'h00, 8'h00, 4'd1},  // R1 count after reset
        {2'd0, 2'd0, 8'h00, 8'h00, 4'd2},
        {2'd0, 2'd1, 8'h37, 8'h00, 4'd3},
        {2'd1, 2'd1, 8'h00, 8'h37, 4'd3},  // R3 readback while stopped
        {2'd2, 2'd0, 8'd5,  8'h00, 4'd2},
        {2'd1, 2'd1, 8'h00, 8'h37, 4'd2},  // R2 hold with source 0
        {2'd0, 2'd2, 8'h3A, 8'h00, 4'd6},
        {2'd1, 2'd2, 8'h00, 8'h3A, 4'd6},
        {2'd0, 2'd0, 8'h11, 8'h00, 4'd5},
        {2'd2, 2'd0, 8'd2,  8'h00, 4'd5},
        {2'd0, 2'd0, 8'h10, 8'h00, 4'd5},
        {2'd1, 2'd1, 8'h00, 8'h3A, 4'd5},  // R5 every-clock source
        {2'd1, 2'd3, 8'h00, 8'h00, 4'd6},  // R6 equality without tick
        {2'd0, 2'd0, 8'h11, 8'h00, 4'd6},
        {2'd2, 2'd0, 8'd1,  8'h00, 4'd6},
        {2'd1, 2'd3, 8'h00, 8'h01, 4'd6},  // R6 flag on tick at equality
        {2'd0, 2'd3, 8'h01, 8'h00, 4'd8},
        {2'd1, 2'd3, 8'h00, 8'h00, 4'd8},  // R8 write-one clear
        {2'd0, 2'd0, 8'h10, 8'h00, 4'd5},
        {2'd1, 2'd1, 8'h00, 8'h3D, 4'd3}   // R3 count after run
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            ext_in = 1'b1; idle(4);
            ext_in = 1'b0; idle(4);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v); check("R1 register", v, 8'h00);
        end
        check("R1 wave", {7'b0, wave_out}, 8'h00);
        check("R1 top/bottom", {6'b0, at_top, at_bottom}, 8'h01);

        for (int i = 0; i < NV; i++) begin
            logic [23:0] e;
            e = VEC[i];
            case (e[23:22])
                2'd0: wr(e[21:20], e[19:12]);
                2'd1: begin
                    rd(e[21:20], v);
                    checks++;
                    if (v !== e[11:4]) begin
                        errors++;
                        $display("FAIL R%0d vector %0d actual %h expected %h", e[3:0], i, v, e[11:4]);
                    end
                end
                default: idle(int'(e[19:12]));
            endcase
        end

        // R4 write beats a step
        wr(2'd0, 8'h01); idle(1);
        wr(2'd1, 8'h80);
        rd(2'd1, v); check("R4 write priority", v, 8'h80);
        idle(1); rd(2'd1, v); check("R4 step after write", v, 8'h81);
        wr(2'd0, 8'h00);

        // R13 top and bottom
        wr(2'd1, 8'hFF); check("R13 at max", {6'b0, at_top, at_bottom}, 8'h02);
        wr(2'd1, 8'h00); check("R13 at zero", {6'b0, at_top, at_bottom}, 8'h01);

        // R9 normal wrap and R7 overflow irq
        wr(2'd3, 8'h03); wr(2'd1, 8'hFE); gie = 1'b1;
        wr(2'd0, 8'h81); idle(1);
        rd(2'd3, v); check("R9 no flag before wrap", v, 8'h00);
        idle(1);
        rd(2'd1, v); check("R9 wrap value", v, 8'h00);
        rd(2'd3, v); check("R9 overflow flag", v, 8'h02);
        check("R7 irq_ovf on", {7'b0, irq_ovf}, 8'h01);
        gie = 1'b0; #1;
        check("R7 irq_ovf gated", {7'b0, irq_ovf}, 8'h00);
        wr(2'd0, 8'h00);

        // R10 up/down turns
        wr(2'd1, 8'hFD); wr(2'd3, 8'h03);
        wr(2'd0, 8'h09); idle(3);
        rd(2'd1, v); check("R10 turn at max", v, 8'hFE);
        rd(2'd3, v); check("R10 no overflow at max", v, 8'h00);
        wr(2'd1, 8'h02); idle(2);
        rd(2'd1, v); check("R10 down to zero", v, 8'h00);
        idle(1);
        rd(2'd1, v); check("R10 turn at zero", v, 8'h01);
        rd(2'd3, v); check("R10 overflow at zero", v, 8'h02);
        wr(2'd0, 8'h00); wr(2'd3, 8'h02);
        rd(2'd3, v); check("R8 overflow write-one clear", v, 8'h00);

        // R7 and R8 compare irq and acknowledge
        wr(2'd2, 8'h10); wr(2'd1, 8'h10);
        wr(2'd0, 8'h41); idle(1);
        gie = 1'b1; #1;
        check("R7 irq_cmp on", {7'b0, irq_cmp}, 8'h01);
        gie = 1'b0; #1;
        check("R7 irq_cmp gated", {7'b0, irq_cmp}, 8'h00);
        gie = 1'b1;
        wr(2'd3, 8'h00);
        rd(2'd3, v); check("R8 write zero keeps flag", v, 8'h01);
        cmp_ack = 1'b1; @(posedge clk); @(negedge clk); cmp_ack = 1'b0;
        rd(2'd3, v); check("R8 ack clears flag", v, 8'h00);
        check("R7 irq_cmp after ack", {7'b0, irq_cmp}, 8'h00);
        wr(2'd0, 8'h00); gie = 1'b0;

        // R11 and R12 wave modes and suppression
        wr(2'd0, 8'h20); wr(2'd2, 8'h20); wr(2'd1, 8'h1F);
        wr(2'd0, 8'h21); idle(2);
        check("R11 clear mode", {7'b0, wave_out}, 8'h00);
        wr(2'd0, 8'h31); wr(2'd1, 8'h20); idle(1);
        check("R12 blocked after write", {7'b0, wave_out}, 8'h00);
        wr(2'd1, 8'h1F); idle(2);
        check("R11 set mode", {7'b0, wave_out}, 8'h01);
        wr(2'd0, 8'h11); wr(2'd1, 8'h1F); idle(2);
        check("R11 toggle to 0", {7'b0, wave_out}, 8'h00);
        wr(2'd1, 8'h1F); idle(2);
        check("R11 toggle to 1", {7'b0, wave_out}, 8'h01);
        wr(2'd0, 8'h00);
        check("R11 disconnected", {7'b0, wave_out}, 8'h00);

        // R5 prescaler taps and external edges
        wr(2'd1, 8'h00); wr(2'd0, 8'h02); idle(80);
        rd(2'd1, v); check("R5 divide by 8", v, 8'd10);
        wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd0, 8'h03); idle(640);
        rd(2'd1, v); check("R5 divide by 64", v, 8'd10);
        wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd0, 8'h07);
        pulses(5); idle(4);
        rd(2'd1, v); check("R5 rising edges", v, 8'd5);
        wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd0, 8'h06);
        pulses(5); idle(4);
        rd(2'd1, v); check("R5 falling edges", v, 8'd5);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule